// File: doc/BRIEF.md
# Compare-Toggle Gate Pulse Unit

This block produces one gate drive level for a switch in a bridge power converter. A free-running period counter steps once per clock and returns to zero after a fixed number of counts. A compare value written by the host is held in a register and checked against the running count. The gate output inverts when the count meets the compare value and inverts again when the counter wraps, so the host sets the pulse width by choosing the compare value.

The counter only advances while an active-low run input is held low. That input can come from the host or from the output of another unit, so several units can be chained, each starting a programmed number of counts after the one before it. The host can also clear the counter, and it can force the gate output high or low to give it a known starting level. The count value is brought out so that neighbouring units can derive their own offsets from it.

Top module: `phase_gate_unit`

## Requirements
- R1: While reset is asserted, and once it is released, the count output is 0 and the gate output is 0.
- R2: With run_n low and ctr_clr low, count_o rises by one at each clock edge. With run_n high it holds its value.
- R3: The count runs from 0 to PERIOD-1 (default 400, so 0..399) and goes from PERIOD-1 to 0 at the next running edge. It never exceeds PERIOD-1.
- R4: ctr_clr high makes count_o 0 at the next edge. This takes priority over counting, and no gate inversion happens in that cycle, even when the count is at PERIOD-1.
- R5: For an active compare value C with 1 <= C <= PERIOD-2, gate_o inverts at the edge that moves the count from C to C+1.
- R6: gate_o inverts at the edge that moves the count from PERIOD-1 to 0.
- R7: With C = PERIOD-1, the match and the wrap fall on the same edge and give a single inversion, so gate_o changes once per period.
- R8: With C = 0 or C >= PERIOD, gate_o changes only at the wrap, once per period.
- R9: A write with cmp_wr high while the counter runs is held back and becomes active only after the next wrap. A write while the counter is stopped or being cleared is active at once.
- R10: gate_set high forces gate_o to 1 at the next edge and gate_clr high forces it to 0. gate_clr wins when both are high, and both override any inversion.
- R11: While run_n is high, gate_o does not change unless gate_set or gate_clr is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_n | input | 1 | Active-low run enable for the period counter |
| ctr_clr | input | 1 | Host forced clear of the counter, active high |
| gate_set | input | 1 | Forces the gate output to 1 |
| gate_clr | input | 1 | Forces the gate output to 0 (wins over gate_set) |
| cmp_wr | input | 1 | Write strobe for the compare value |
| cmp_data | input | CNT_W | Compare value to write |
| gate_o | output | 1 | Gate drive level |
| count_o | output | CNT_W | Running count for neighbouring units |

## Verification
Every register result is due one clock edge after the input that causes it. That holds for the count step, the clear, the gate inversion on match or wrap, and set or clear of the gate. A compare write made while the counter runs shows up only after the following wrap, up to PERIOD edges later. Reset release takes two further edges through the synchroniser before counting can begin. The bench changes inputs and samples outputs only on falling clock edges. Pulse edges are checked by the count value seen just after the gate level changes: C+1 for a match and 0 for a wrap.

// File: rtl/phase_gate_pkg.sv
package phase_gate_pkg;

  // Events that invert the gate output in one cycle
  typedef struct packed {
    logic wrap;
    logic match;
  } tog_evt_t;

  function automatic logic any_evt(input tog_evt_t e);
    return e.wrap | e.match;
  endfunction

endpackage

// File: rtl/phase_gate_rst_sync.sv
module phase_gate_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/phase_gate_ctr.sv
module phase_gate_ctr #(
  parameter int PERIOD = 400,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign wrap   = run & ~clr & (cnt_q == LAST);
  assign cnt_en = clr | run;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/phase_gate_cmp_reg.sv
module phase_gate_cmp_reg #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             commit,
  output logic [CNT_W-1:0] act
);
  logic [CNT_W-1:0] shadow_q, act_q, act_d;

  // A write in the commit cycle is taken directly
  assign act_d = wr ? wdata : shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  shadow_q <= '0;
    else if (wr) shadow_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (commit) act_q <= act_d;
  end

  assign act = act_q;
endmodule

// File: rtl/phase_gate_out_ff.sv
module phase_gate_out_ff
  import phase_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set,
  input  logic     clr,
  input  tog_evt_t evt,
  output logic     gate
);
  logic gate_q, gate_d, gate_en;

  assign gate_en = set | clr | any_evt(evt);

  always_comb begin
    gate_d = gate_q;
    if (clr)                gate_d = 1'b0;
    else if (set)           gate_d = 1'b1;
    else if (any_evt(evt))  gate_d = ~gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gate_q <= 1'b0;
    else if (gate_en) gate_q <= gate_d;
  end

  assign gate = gate_q;
endmodule

// File: rtl/phase_gate_unit.sv
module phase_gate_unit
  import phase_gate_pkg::*;
#(
  parameter int PERIOD = 400,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_n,
  input  logic             ctr_clr,
  input  logic             gate_set,
  input  logic             gate_clr,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_data,
  output logic             gate_o,
  output logic [CNT_W-1:0] count_o
);
  logic             rst_q_n;
  logic             run;
  logic             wrap;
  logic             commit;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp_act;
  tog_evt_t         evt;

  assign run = ~run_n;

  phase_gate_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  phase_gate_ctr #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_q_n),
    .run   (run),
    .clr   (ctr_clr),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  // New compare value goes live at wrap, or at once when the counter is idle
  assign commit = wrap | ctr_clr | run_n;

  phase_gate_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr     (cmp_wr),
    .wdata  (cmp_data),
    .commit (commit),
    .act    (cmp_act)
  );

  // Comparator blanked at terminal count and for a zero value
  assign evt.match = run & ~ctr_clr & ~wrap & (cmp_act != '0) & (cnt == cmp_act);
  assign evt.wrap  = wrap;

  phase_gate_out_ff u_out (
    .clk   (clk),
    .rst_n (rst_q_n),
    .set   (gate_set),
    .clr   (gate_clr),
    .evt   (evt),
    .gate  (gate_o)
  );

  assign count_o = cnt;
endmodule

// File: rtl/phase_gate_unit_chk.sv
module phase_gate_unit_chk #(
  parameter int PERIOD = 400,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input logic             clk,
  input logic             arst_n,
  input logic             run_n,
  input logic             ctr_clr,
  input logic             gate_set,
  input logic             gate_clr,
  input logic             gate_o,
  input logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    (run_n && !ctr_clr) |=> $stable(count_o)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    (!run_n && !ctr_clr && count_o != LAST) |=> (count_o == CNT_W'($past(count_o) + 1'b1))); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    (!run_n && !ctr_clr && count_o == LAST) |=> (count_o == '0)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!arst_n)
    count_o <= LAST); // R3

  AST_FORCE_CLEAR: assert property (@(posedge clk) disable iff (!arst_n)
    ctr_clr |=> (count_o == '0)); // R4

  AST_CLEAR_NO_TOGGLE: assert property (@(posedge clk) disable iff (!arst_n)
    (ctr_clr && !gate_set && !gate_clr) |=> $stable(gate_o)); // R4

  AST_GATE_SET: assert property (@(posedge clk) disable iff (!arst_n)
    (gate_set && !gate_clr) |=> gate_o); // R10

  AST_GATE_CLR: assert property (@(posedge clk) disable iff (!arst_n)
    gate_clr |=> !gate_o); // R10

  AST_STOPPED_STABLE: assert property (@(posedge clk) disable iff (!arst_n)
    (run_n && !gate_set && !gate_clr) |=> $stable(gate_o)); // R11
endmodule

bind phase_gate_unit phase_gate_unit_chk #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .arst_n   (rst_q_n),
  .run_n    (run_n),
  .ctr_clr  (ctr_clr),
  .gate_set (gate_set),
  .gate_clr (gate_clr),
  .gate_o   (gate_o),
  .count_o  (count_o)
);

// File: tb/phase_gate_unit_tb.sv
`timescale 1ns/1ps
module phase_gate_unit_tb;
  localparam int P  = 400;
  localparam int CW = $clog2(P);

  logic          clk;
  logic          rst_n;
  logic          run_n;
  logic          ctr_clr;
  logic          gate_set;
  logic          gate_clr;
  logic          cmp_wr;
  logic [CW-1:0] cmp_data;
  logic          gate_o;
  logic [CW-1:0] count_o;

  int checks;
  int failures;

  phase_gate_unit #(.PERIOD(P)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_n    (run_n),
    .ctr_clr  (ctr_clr),
    .gate_set (gate_set),
    .gate_clr (gate_clr),
    .cmp_wr   (cmp_wr),
    .cmp_data (cmp_data),
    .gate_o   (gate_o),
    .count_o  (count_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Step n edges, count gate changes and the count seen after the first
  task automatic watch(input int n, output int changes, output int first_at);
    logic prev;
    prev = gate_o;
    changes = 0;
    first_at = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gate_o !== prev) begin
        changes++;
        if (changes == 1) first_at = int'(count_o);
        prev = gate_o;
      end
    end
  endtask

  // Stop, clear counter, load compare value and gate level
  task automatic prep(input int c, input logic g);
    run_n = 1'b1; ctr_clr = 1'b1; cmp_wr = 1'b1; cmp_data = CW'(c);
    gate_set = g; gate_clr = ~g;
    step(1);
    ctr_clr = 1'b0; cmp_wr = 1'b0; gate_set = 1'b0; gate_clr = 1'b0;
    step(1);
  endtask

  task automatic t_reset();
    chk(int'(count_o), 0, "R1 count after reset");
    chk(int'(gate_o), 0, "R1 gate after reset");
  endtask

  task automatic t_count();
    prep(0, 1'b0);
    step(5);
    chk(int'(count_o), 0, "R2 hold while stopped");
    run_n = 1'b0;
    step(10);
    chk(int'(count_o), 10, "R2 count after 10 edges");
    run_n = 1'b1;
    step(3);
    chk(int'(count_o), 10, "R2 hold after stop");
  endtask

  task automatic t_wrap_only(input int c, input string tag);
    int ch, fa;
    prep(c, 1'b0);
    run_n = 1'b0;
    step(P - 1);
    chk(int'(count_o), P - 1, {tag, " count at last"});
    chk(int'(gate_o), 0, {tag, " no mid-period toggle"});
    watch(1, ch, fa);
    chk(int'(count_o), 0, "R3 wrap to zero");
    chk(ch, 1, "R6 wrap inverts gate");
    watch(P, ch, fa);
    chk(ch, 1, {tag, " one change per period"});
    chk(fa, 0, {tag, " change at wrap"});
  endtask

  task automatic t_width(input int c);
    int ch, fa;
    prep(c, 1'b1);
    run_n = 1'b0;
    watch(P, ch, fa);
    chk(ch, 2, "R5 two changes per period");
    chk(fa, c + 1, "R5 match edge");
    chk(int'(gate_o), 1, "R6 high again after wrap");
  endtask

  task automatic t_late_write();
    int ch, fa;
    prep(50, 1'b1);
    run_n = 1'b0;
    step(10);
    cmp_wr = 1'b1; cmp_data = CW'(200);
    step(1);
    cmp_wr = 1'b0;
    watch(P - 11, ch, fa);
    chk(fa, 51, "R9 old value kept this period");
    chk(ch, 2, "R9 old period changes");
    watch(P, ch, fa);
    chk(fa, 201, "R9 new value after wrap");
  endtask

  task automatic t_clear();
    prep(0, 1'b0);
    run_n = 1'b0;
    step(P - 1);
    ctr_clr = 1'b1;
    step(1);
    ctr_clr = 1'b0;
    chk(int'(count_o), 0, "R4 clear at last count");
    chk(int'(gate_o), 0, "R4 no toggle on clear");
    prep(100, 1'b1);
    run_n = 1'b0;
    step(30);
    ctr_clr = 1'b1;
    step(1);
    ctr_clr = 1'b0;
    chk(int'(count_o), 0, "R4 clear mid-count");
    chk(int'(gate_o), 1, "R4 gate kept on clear");
  endtask

  task automatic t_force();
    prep(0, 1'b0);
    run_n = 1'b0;
    step(5);
    gate_set = 1'b1;
    step(1);
    gate_set = 1'b0;
    chk(int'(gate_o), 1, "R10 set");
    gate_set = 1'b1; gate_clr = 1'b1;
    step(1);
    gate_set = 1'b0; gate_clr = 1'b0;
    chk(int'(gate_o), 0, "R10 clear wins");
    step(P - 8);
    chk(int'(count_o), P - 1, "R10 at last count");
    gate_clr = 1'b1;
    step(1);
    gate_clr = 1'b0;
    chk(int'(gate_o), 0, "R10 clear overrides wrap");
  endtask

  task automatic t_stopped();
    prep(5, 1'b1);
    run_n = 1'b0;
    step(5);
    run_n = 1'b1;
    chk(int'(count_o), 5, "R11 count at compare");
    step(20);
    chk(int'(gate_o), 1, "R11 no toggle while stopped");
    chk(int'(count_o), 5, "R11 count held");
    run_n = 1'b0;
    step(1);
    chk(int'(gate_o), 0, "R5 toggle after resume");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; run_n = 1'b1; ctr_clr = 1'b0;
    gate_set = 1'b0; gate_clr = 1'b0; cmp_wr = 1'b0; cmp_data = '0;
    step(3);
    chk(int'(count_o), 0, "R1 count in reset");
    chk(int'(gate_o), 0, "R1 gate in reset");
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_count();
    t_wrap_only(0, "R8 zero");
    t_wrap_only(500, "R8 above period");
    t_wrap_only(P - 1, "R7 last");
    t_width(100);
    t_width(1);
    t_width(P - 2);
    t_late_write();
    t_clear();
    t_force();
    t_stopped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule